// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Completion

This block takes a parameterised set of level interrupt sources (IDs 1 to `NSRC`, ID 0 reserved) and routes them to `NCTX` processor contexts. Every source has a small priority value. Every context has its own enable mask, its own priority threshold and a claim/completion register. A context's interrupt line is high while at least one source is pending, enabled for it and above its threshold.

Handler software reads the claim register of its context. The read returns the best qualifying source and takes that source out of the pending state in the same access. The source then stays locked, even if its level is still high, until software writes the same ID back to a claim register. Software keeps claiming and completing until a claim returns 0. Register access uses a plain 32-bit bus with byte addresses. Read data is combinational within the access cycle, and writes take effect at the clock edge.

Each source has a gateway state machine with three states. `GW_IDLE` is open and waiting for the level. `GW_PEND` is latched pending. `GW_CLAIMED` is taken by a handler. The transitions are:
- **latch**: `GW_IDLE`→`GW_PEND` when the level is high at a clock edge.
- **take**: `GW_PEND`→`GW_CLAIMED` on a claim read that selects the source.
- **release**: `GW_CLAIMED`→`GW_IDLE` on a completion write carrying its ID.

Top module: `pic_top`

## Requirements
- R1: After reset every priority, enable, threshold, pending and claimed state is zero. All `irq` bits are low and every claim read returns 0.
- R2: The priority of source n is at byte address 4*n. It holds 3 bits and the upper bits read zero. Address 0 (source 0) always reads zero and ignores writes.
- R3: The enable mask of context c is at 0x2000 + 0x80*c. Source n is bit n%32 of word n/32. Bit 0 and bits of nonexistent sources read zero. Enables of one context do not affect another context.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. It holds 3 bits and the upper bits read zero. The claim/completion register is 4 bytes above it.
- R5: `irq[c]` is high exactly when some source is pending, enabled for c and has a priority strictly greater than c's threshold. A priority equal to the threshold never interrupts.
- R6: Among qualifying sources a claim returns the highest priority. Ties go to the lowest source ID.
- R7: A claim read returns the winner and moves it out of pending at the same edge. While claimed, the source does not become pending again even if its level stays high.
- R8: Writing a claimed source's ID to a claim register releases it. If its level is still high, it is pending again two edges later. If its level is low, it stays idle.
- R9: A completion write carrying an ID that is not claimed, is 0, or is above `NSRC` changes nothing.
- R10: A claim read returns 0 when nothing qualifies. Reads of unmapped addresses return 0.
- R11: Once latched, pending holds even after the source's level falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NSRC (bits NSRC:1) | Level of each interrupt source |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a claim read has a side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | NCTX | Interrupt request per context |

## Verification
A claim read and the rising level of a different, higher-priority source can land on the same clock edge. The bench raises source 3's level in the same cycle that it issues a claim read to context 0, while only source 5 is pending. The read must return 5, because the winner is chosen from the state before the edge. The next claim read must return 3.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {GW_IDLE, GW_PEND, GW_CLAIMED} gw_state_e;
    typedef enum logic [2:0] {RG_NONE, RG_PRIO, RG_EN, RG_THR, RG_CLAIM} region_e;

    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic claim,
    input  logic complete,
    output logic pending,
    output logic claimed
);
    gw_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= GW_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            GW_IDLE:    if (level)    st_nx = GW_PEND;
            GW_PEND:    if (claim)    st_nx = GW_CLAIMED;
            GW_CLAIMED: if (complete) st_nx = GW_IDLE;
            default:                  st_nx = GW_IDLE;
        endcase
    end

    always_comb begin
        pending = (st == GW_PEND);
        claimed = (st == GW_CLAIMED);
    end

    AST_CLAIM_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> pending);                                   // R7
    AST_CLAIM_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> claimed);                                   // R7
    AST_HOLD_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed && !complete) |=> claimed);                  // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !claim) |=> pending);                     // R11
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC:1]            pend,
    input  logic [NSRC:1]            en,
    input  logic [NSRC*PRIO_W-1:0]   prio_flat,
    input  logic [PRIO_W-1:0]        thr,
    output logic [ID_W-1:0]          best_id,
    output logic                     irq
);
    logic [PRIO_W-1:0] best_p;

    // Strict compare starting from the threshold: enforces the threshold and
    // keeps the lowest ID on equal priority.
    always_comb begin
        best_id = '0;
        best_p  = thr;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && (prio_flat[(i-1)*PRIO_W +: PRIO_W] > best_p)) begin
                best_p  = prio_flat[(i-1)*PRIO_W +: PRIO_W];
                best_id = ID_W'(i);
            end
        end
        irq = (best_id != '0);
    end

    AST_WINNER_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend[best_id] && en[best_id]));              // R5
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_level,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   irq
);
    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int NWORDS = (NSRC + 32) / 32;
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int WRD_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [31:0] PRIO_END = 32'((NSRC + 1) * 4);
    localparam logic [31:0] EN_END   = EN_BASE + EN_STRIDE * 32'(NCTX);
    localparam logic [31:0] CTX_END  = CTX_BASE + CTX_STRIDE * 32'(NCTX);

    function automatic logic [NWORDS*32-1:0] make_mask();
        logic [NWORDS*32-1:0] m = '0;
        for (int i = 1; i <= NSRC; i++) m[i] = 1'b1;
        return m;
    endfunction
    localparam logic [NWORDS*32-1:0] EN_MASK = make_mask();

    logic [PRIO_W-1:0]      prio_q [NSRC+1];
    logic [NWORDS*32-1:0]   en_q   [NCTX];
    logic [PRIO_W-1:0]      thr_q  [NCTX];
    logic [ID_W-1:0]        best   [NCTX];
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NSRC:1]          pend_vec, claimed_vec, claim_vec, comp_vec;

    // ---------------- address decode ----------------
    region_e           region;
    logic [ID_W-1:0]   sel_id;
    logic [CTX_W-1:0]  sel_ctx;
    logic [WRD_W-1:0]  sel_word;
    logic [31:0]       a32, eoff, coff;

    always_comb begin
        a32      = 32'(bus_addr);
        eoff     = a32 - EN_BASE;
        coff     = a32 - CTX_BASE;
        region   = RG_NONE;
        sel_id   = '0;
        sel_ctx  = '0;
        sel_word = '0;
        if (a32 < PRIO_END) begin
            region = RG_PRIO;
            sel_id = ID_W'(a32 >> 2);
        end else if (a32 >= EN_BASE && a32 < EN_END) begin
            sel_ctx  = CTX_W'(eoff >> 7);
            sel_word = WRD_W'(eoff[6:2]);
            if (32'(eoff[6:2]) < 32'(NWORDS)) region = RG_EN;
        end else if (a32 >= CTX_BASE && a32 < CTX_END) begin
            sel_ctx = CTX_W'(coff >> 12);
            if (coff[11:0] == 12'h000)      region = RG_THR;
            else if (coff[11:0] == 12'h004) region = RG_CLAIM;
        end
    end

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NSRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (bus_wr) begin
            unique case (region)
                RG_PRIO: if (sel_id != '0) prio_q[sel_id] <= bus_wdata[PRIO_W-1:0];
                RG_EN:   en_q[sel_ctx][{sel_word, 5'b0} +: 32] <=
                             bus_wdata & EN_MASK[{sel_word, 5'b0} +: 32];
                RG_THR:  thr_q[sel_ctx] <= bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        unique case (region)
            RG_PRIO:  bus_rdata = 32'(prio_q[sel_id]);
            RG_EN:    bus_rdata = en_q[sel_ctx][{sel_word, 5'b0} +: 32];
            RG_THR:   bus_rdata = 32'(thr_q[sel_ctx]);
            RG_CLAIM: bus_rdata = 32'(best[sel_ctx]);
            default:  bus_rdata = '0;
        endcase
    end

    // ---------------- per-source gateways ----------------
    for (genvar g = 1; g <= NSRC; g++) begin : g_src
        assign prio_flat[(g-1)*PRIO_W +: PRIO_W] = prio_q[g];
        assign claim_vec[g] = bus_rd && (region == RG_CLAIM) && (best[sel_ctx] == ID_W'(g));
        assign comp_vec[g]  = bus_wr && (region == RG_CLAIM) && (bus_wdata == 32'(g));
        pic_gateway u_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (src_level[g]),
            .claim    (claim_vec[g]),
            .complete (comp_vec[g]),
            .pending  (pend_vec[g]),
            .claimed  (claimed_vec[g])
        );
    end

    // ---------------- per-context arbiters ----------------
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend      (pend_vec),
            .en        (en_q[c][NSRC:1]),
            .prio_flat (prio_flat),
            .thr       (thr_q[c]),
            .best_id   (best[c]),
            .irq       (irq[c])
        );
    end

    AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));                                 // R7
    AST_CLAIM_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && region == RG_CLAIM && bus_rdata == 32'd0) |-> !irq[sel_ctx]); // R10
    AST_CLAIMED_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_vec != '0) |=> ((pend_vec & $past(claim_vec)) == '0)); // R7
endmodule

// File: tb/sim_pic_top.sv
`timescale 1ns/1ps
module sim_pic_top;
    localparam int NSRC = 31;
    localparam int NCTX = 2;
    localparam logic [25:0] CLM0 = 26'h200004;
    localparam logic [25:0] CLM1 = 26'h201004;
    localparam logic [25:0] THR0 = 26'h200000;
    localparam logic [25:0] THR1 = 26'h201000;
    localparam logic [25:0] EN0  = 26'h002000;
    localparam logic [25:0] EN1  = 26'h002080;

    logic clk = 0, rst_n = 0;
    logic [NSRC:1] lvl = '0;
    logic [25:0] addr = '0;
    logic wr = 0, rd = 0;
    logic [31:0] wdata = '0, rdata;
    logic [NCTX-1:0] irq;
    int checks = 0, errors = 0;
    logic [31:0] d;

    always #4 clk = ~clk;

    pic_top #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(26)) u0 (
        .clk(clk), .rst_n(rst_n), .src_level(lvl), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

    // sources 3 and 5: priorities, context-0 threshold, expected claim result
    typedef struct packed {logic [2:0] pa; logic [2:0] pb; logic [2:0] thr; logic [4:0] exp;} vec_t;
    localparam vec_t VECS [7] = '{
        '{3'd2, 3'd5, 3'd0, 5'd5},
        '{3'd5, 3'd2, 3'd0, 5'd3},
        '{3'd4, 3'd4, 3'd0, 5'd3},
        '{3'd4, 3'd4, 3'd4, 5'd0},
        '{3'd0, 3'd0, 3'd0, 5'd0},
        '{3'd1, 3'd3, 3'd2, 5'd5},
        '{3'd7, 3'd6, 3'd6, 5'd3}};

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [25:0] a, input logic [31:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic rd_reg(input logic [25:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd = 1;
        #1 v = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3); rst_n = 1; idle(1);
        // R1 reset state
        #1 chk(irq == '0, "R1 irq", 32'(irq), 0);
        rd_reg(CLM0, d); chk(d == 0, "R1 claim", d, 0);
        rd_reg(26'd12, d); chk(d == 0, "R1 prio", d, 0);
        rd_reg(EN1, d);   chk(d == 0, "R1 enable", d, 0);
        // R2 priority field width, source 0
        wr_reg(26'd12, 32'hFFFF_FFFF); rd_reg(26'd12, d); chk(d == 7, "R2 width", d, 7);
        wr_reg(26'd0, 32'd5); rd_reg(26'd0, d); chk(d == 0, "R2 source0", d, 0);
        // R3 enable mask bit 0
        wr_reg(EN0, 32'hFFFF_FFFF); rd_reg(EN0, d); chk(d == 32'hFFFF_FFFE, "R3 bit0", d, 32'hFFFF_FFFE);
        wr_reg(EN0, 0);
        // R4 threshold width
        wr_reg(THR1, 32'hF); rd_reg(THR1, d); chk(d == 7, "R4 thr", d, 7);
        wr_reg(THR1, 0);
        // R10 unmapped
        rd_reg(26'h001000, d); chk(d == 0, "R10 unmapped", d, 0);
        rd_reg(26'h200008, d); chk(d == 0, "R10 ctx gap", d, 0);

        // table: R5 R6 R7 R8
        wr_reg(EN0, 32'h28);
        lvl[3] = 1; lvl[5] = 1;
        for (int k = 0; k < 7; k++) begin
            wr_reg(26'd12, 32'(VECS[k].pa));
            wr_reg(26'd20, 32'(VECS[k].pb));
            wr_reg(THR0, 32'(VECS[k].thr));
            idle(2);
            #1 chk(irq[0] == (VECS[k].exp != 0), "R5 irq", 32'(irq[0]), 32'(VECS[k].exp != 0));
            rd_reg(CLM0, d); chk(d == 32'(VECS[k].exp), "R6 claim", d, 32'(VECS[k].exp));
            if (d != 0) wr_reg(CLM0, d);
            idle(2);
        end

        // R11 pending held after level falls
        wr_reg(THR0, 0); wr_reg(26'd12, 2); wr_reg(26'd20, 1);
        lvl[3] = 0; lvl[5] = 0; idle(2);
        rd_reg(CLM0, d); chk(d == 3, "R11 sticky", d, 3);
        // R7 claimed source locked while level high
        lvl[3] = 1; idle(3);
        rd_reg(CLM0, d); chk(d == 5, "R7 locked", d, 5);
        wr_reg(CLM0, 5);
        // R9 bogus completions
        wr_reg(CLM0, 5); wr_reg(CLM0, 40); wr_reg(CLM0, 0); idle(2);
        rd_reg(CLM0, d); chk(d == 0, "R9 ignored", d, 0);
        #1 chk(irq[0] == 0, "R9 irq", 32'(irq[0]), 0);
        // R8 completion with level high re-pends
        wr_reg(CLM0, 3); idle(2);
        rd_reg(CLM0, d); chk(d == 3, "R8 repend", d, 3);
        lvl[3] = 0; wr_reg(CLM0, 3); idle(2);
        rd_reg(CLM0, d); chk(d == 0, "R8 level low", d, 0);

        // R3 context isolation
        wr_reg(EN1, 32'h80); wr_reg(26'd28, 1);
        lvl[7] = 1; idle(2); lvl[7] = 0; idle(1);
        #1 chk(irq == 2'b10, "R3 ctx1 only", 32'(irq), 2);
        rd_reg(CLM1, d); chk(d == 7, "R3 ctx1 claim", d, 7);
        rd_reg(CLM0, d); chk(d == 0, "R3 ctx0 quiet", d, 0);

        // same-edge claim and new higher-priority level
        wr_reg(26'd12, 5); wr_reg(26'd20, 2);
        lvl[5] = 1; idle(2);
        @(negedge clk); addr = CLM0; rd = 1; lvl[3] = 1;
        #1 d = rdata;
        @(negedge clk); rd = 0;
        chk(d == 5, "R6 same edge", d, 5);
        idle(1);
        rd_reg(CLM0, d); chk(d == 3, "R7 next claim", d, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule